// File: doc/BRIEF.md
# Reset Supervisor with Watchdog

This block produces the system reset for a processor subsystem from three conditions. The first is a supply-good flag that an external comparator has already turned into a logic level. The second is an active-low manual reset request. The third is the strobe of a watchdog that the running software must keep toggling. All three pass through two-flop synchronizers. A bad supply or a low manual request asserts reset in the cycle its synchronized value arrives. Reset is then held until every cause has been clear for a fixed release delay.

The watchdog sees rising and falling strobe edges alike. If the reset is released and no edge arrives for the timeout interval, the watchdog raises a reset pulse exactly one release delay long. The timeout window starts again when that pulse ends. The watchdog can be switched off with a static enable, which stands for a strobe pin left unconnected.

Both durations are parameters counted in clock cycles. At a 50 MHz clock the defaults give a 200 ms delay and a 1.6 s timeout. A short-delay setting would be 1,250,000 and 10,000,000 cycles (25 ms and 200 ms). Reset is driven both active-low and active-high.

Top module: `reset_supervisor`

## Requirements
- R1: When `supply_ok` falls to 0, `rst_out_n` is 0 from the second rising clock edge after the change. It stays 0 for as long as `supply_ok` is 0.
- R2: Once the last cause clears, reset stays asserted for exactly DELAY_CYCLES cycles beyond the synchronizer. Seen from the input change, that is DELAY_CYCLES+1 cycles. If a cause returns during the delay, the delay starts over.
- R3: `man_rst_n` at 0 asserts reset with the same two-edge latency as R1. Its return to 1 is followed by the same release timing as R2.
- R4: `rst_out_n` becomes 1 only when `supply_ok` is 1 and `man_rst_n` is 1. Every other combination keeps it at 0.
- R5: The watchdog is retriggered by a rising or a falling edge of `wd_strobe`. A strobe that toggles at least every TIMEOUT_CYCLES-2 cycles never causes a reset.
- R6: While reset is released and `wd_enable` is 1, TIMEOUT_CYCLES cycles without a strobe edge assert reset. That reset lasts exactly DELAY_CYCLES cycles.
- R7: After any reset is released, the watchdog window starts again from zero, so the next timeout comes TIMEOUT_CYCLES cycles after release.
- R8: With `wd_enable` at 0, no timeout reset occurs, however long the strobe stays idle.
- R9: `rst_out` is the complement of `rst_out_n` in every cycle.
- R10: Strobe edges that arrive while reset is asserted neither shorten nor lengthen the release delay. They also do not pre-load the watchdog window that follows.
- R11: While `por_n` is 0, reset is asserted. After `por_n` rises with good inputs, release follows DELAY_CYCLES+1 cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on clear, active low |
| supply_ok | input | 1 | Supply-good flag from the comparator, 1 = good |
| man_rst_n | input | 1 | Manual reset request, active low |
| wd_strobe | input | 1 | Watchdog strobe; either edge retriggers |
| wd_enable | input | 1 | Static watchdog enable, 1 = on |
| rst_out_n | output | 1 | Reset, active low |
| rst_out | output | 1 | Reset, active high |

## Verification
Two functions can fall in the same cycle: a watchdog expiry and an arriving reset cause. Strobe activity can also land during reset while the delay counter and the watchdog counter both react. The bench holds the manual request low while toggling the strobe every cycle, then checks the exact release length. It then checks that the next window is a full TIMEOUT_CYCLES long. It also sweeps strobe periods on both sides of the timeout, with expected pulse and window lengths counted arithmetically from the two parameters.

// File: rtl/reset_supervisor.sv
module reset_supervisor #(
  parameter int unsigned DELAY_CYCLES   = 10_000_000,
  parameter int unsigned TIMEOUT_CYCLES = 80_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic man_rst_n,
  input  logic wd_strobe,
  input  logic wd_enable,
  output logic rst_out_n,
  output logic rst_out
);

  localparam int DW = $clog2(DELAY_CYCLES + 1);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [DW-1:0] DLY_LAST = DW'(DELAY_CYCLES - 1);
  localparam logic [TW-1:0] WD_LAST  = TW'(TIMEOUT_CYCLES - 1);

  logic [1:0]    sup_sync, man_sync;
  logic [2:0]    wd_sync;
  logic          rst_q;
  logic [DW-1:0] dly_cnt;
  logic [TW-1:0] wd_cnt;
  logic          cause, wd_kick, wd_fire;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      sup_sync <= '0;
      man_sync <= '0;
      wd_sync  <= '0;
    end else begin
      sup_sync <= {sup_sync[0], supply_ok};
      man_sync <= {man_sync[0], man_rst_n};
      wd_sync  <= {wd_sync[1:0], wd_strobe};
    end
  end

  assign cause   = !sup_sync[1] || !man_sync[1];
  assign wd_kick = wd_sync[2] ^ wd_sync[1];
  assign wd_fire = wd_enable && !rst_q && !cause && !wd_kick && (wd_cnt == WD_LAST);

  always_ff @(posedge clk) begin
    if (!por_n || cause || wd_fire) begin
      rst_q   <= 1'b1;
      dly_cnt <= '0;
    end else if (rst_q) begin
      if (dly_cnt == DLY_LAST) begin
        rst_q   <= 1'b0;
        dly_cnt <= '0;
      end else begin
        dly_cnt <= dly_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n || rst_q || cause || !wd_enable || wd_kick || wd_fire)
      wd_cnt <= '0;
    else
      wd_cnt <= wd_cnt + 1'b1;
  end

  assign rst_out_n = !(rst_q || cause);
  assign rst_out   = rst_q || cause;

  p_hold_r2: assert property (@(posedge clk) disable iff (!por_n)
    (rst_q && !cause && dly_cnt != DLY_LAST) |=> rst_q);

  p_release_r2: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_q) |-> ($past(dly_cnt) == DLY_LAST));

  p_fire_pulse_r6: assert property (@(posedge clk) disable iff (!por_n)
    wd_fire |=> (rst_q && dly_cnt == '0));

  p_wd_bound_r6: assert property (@(posedge clk) disable iff (!por_n)
    wd_cnt <= WD_LAST);

  p_wd_held_r10: assert property (@(posedge clk) disable iff (!por_n)
    (rst_q && $past(rst_q)) |-> (wd_cnt == '0));

  p_wd_off_r8: assert property (@(posedge clk) disable iff (!por_n)
    (!wd_enable && $past(!wd_enable)) |-> (wd_cnt == '0));

endmodule

// File: tb/reset_supervisor_test.sv
module reset_supervisor_test;
  localparam int D = 8;
  localparam int T = 20;

  logic clk = 1'b0;
  logic por_n, supply_ok, man_rst_n, wd_strobe, wd_enable;
  logic rst_out_n, rst_out;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   mon_on = 1'b0;

  always #10 clk = ~clk;

  reset_supervisor #(.DELAY_CYCLES(D), .TIMEOUT_CYCLES(T)) uut (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .man_rst_n(man_rst_n),
    .wd_strobe(wd_strobe), .wd_enable(wd_enable),
    .rst_out_n(rst_out_n), .rst_out(rst_out));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_while(input logic lvl, output int n);
    n = 0;
    while (rst_out_n === lvl && n < 10000) begin
      n++;
      @(negedge clk);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      n_cmp++;
      if (rst_out !== !rst_out_n) begin
        n_bad++;
        $display("FAIL R9: actual rst_out=%0d expected %0d", rst_out, !rst_out_n);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    int seen;
    int i;
    por_n = 0; supply_ok = 1; man_rst_n = 1; wd_strobe = 0; wd_enable = 0;
    repeat (5) @(negedge clk);
    mon_on = 1'b1;
    chk("R11 rst_out_n in clear", rst_out_n, 0);
    chk("R11 rst_out in clear", rst_out, 1);
    por_n = 1;
    @(negedge clk); count_while(1'b0, n);
    chk("R11 release after clear", n, D + 1);

    supply_ok = 0;
    @(negedge clk); chk("R1 one edge", rst_out_n, 1);
    @(negedge clk); chk("R1 two edges", rst_out_n, 0);
    repeat (3 * D) @(negedge clk);
    chk("R1 held", rst_out_n, 0);
    supply_ok = 1;
    @(negedge clk); count_while(1'b0, n);
    chk("R2 delay", n, D + 1);

    man_rst_n = 0;
    @(negedge clk); chk("R3 one edge", rst_out_n, 1);
    @(negedge clk); chk("R3 two edges", rst_out_n, 0);
    repeat (D) @(negedge clk);
    man_rst_n = 1;
    @(negedge clk); count_while(1'b0, n);
    chk("R3 delay", n, D + 1);

    supply_ok = 0; repeat (4) @(negedge clk);
    supply_ok = 1; repeat (5) @(negedge clk);
    chk("R2 mid delay", rst_out_n, 0);
    supply_ok = 0; @(negedge clk);
    supply_ok = 1; @(negedge clk);
    count_while(1'b0, n);
    chk("R2 restart", n, D + 1);

    for (int c = 0; c < 4; c++) begin
      supply_ok = c[1]; man_rst_n = c[0];
      repeat (D + 4) @(negedge clk);
      chk($sformatf("R4 combo %0d", c), rst_out_n, c[1] & c[0]);
    end
    supply_ok = 0; repeat (3) @(negedge clk);
    man_rst_n = 0; repeat (3) @(negedge clk);
    supply_ok = 1; repeat (2 * D) @(negedge clk);
    chk("R4 overlap", rst_out_n, 0);
    man_rst_n = 1;
    @(negedge clk); count_while(1'b0, n);
    chk("R4 overlap release", n, D + 1);

    wd_enable = 1;
    count_while(1'b1, n); chk("R6 timeout", n, T);
    count_while(1'b0, n); chk("R6 pulse", n, D);
    count_while(1'b1, n); chk("R7 window restart", n, T);
    count_while(1'b0, n); chk("R6 pulse again", n, D);

    for (int p = 1; p <= T - 2; p++) begin
      seen = 0;
      for (int k = 0; k < 5 * T; k++) begin
        if (k % p == 0) wd_strobe = !wd_strobe;
        if (rst_out_n !== 1'b1) seen++;
        @(negedge clk);
      end
      chk($sformatf("R5 period %0d", p), seen, 0);
      count_while(1'b1, n);
      count_while(1'b0, n);
      chk("R6 pulse after sweep", n, D);
    end

    for (int p = T + 2; p <= T + 6; p += 4) begin
      i = 0;
      while (rst_out_n === 1'b1 && i < 3 * T) begin
        if (i % p == 0) wd_strobe = !wd_strobe;
        @(negedge clk);
        i++;
      end
      chk($sformatf("R5 slow period %0d fires", p), rst_out_n, 0);
      count_while(1'b0, n);
      chk("R6 slow pulse", n, D);
    end

    man_rst_n = 0;
    for (int k = 0; k < 4 * D; k++) begin
      wd_strobe = !wd_strobe;
      @(negedge clk);
    end
    man_rst_n = 1;
    @(negedge clk); count_while(1'b0, n);
    chk("R10 delay with strobe", n, D + 1);
    count_while(1'b1, n); chk("R10 clean window", n, T);
    count_while(1'b0, n); chk("R6 pulse after R10", n, D);

    wd_enable = 0;
    seen = 0;
    repeat (4 * T) begin
      if (rst_out_n !== 1'b1) seen++;
      @(negedge clk);
    end
    chk("R8 disabled", seen, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule